// File: doc/BRIEF.md
# Idle/Stop Power-Mode Controller

This controller sits between a small processor core and the clock and reset logic around it. The core writes a two-bit mode register to request one of two low-power states. The light state halts only the CPU clock, so peripherals and the interrupt logic keep running. The deep state also turns off the fast internal oscillator. Neither state takes effect until the instruction that wrote the register has retired.

The light state ends when an enabled interrupt arrives. The controller then clears the light-state bit by itself, and the CPU resumes after its service routine. The deep state ignores interrupts and ends only on a reset. A watchdog request, or a clock monitor that finds the fast clock missing, can cause that reset. The clock monitor runs on an always-on slow clock. It raises an internal reset request when it sees no activity on the fast clock for a set number of slow ticks. All reset requests leave the block as a single-tick pulse in the slow-clock domain. The surrounding reset logic acts on that pulse.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After `rst_n` and `por_n` are released, `pmode_q` reads 0, `cpu_clk_en` and `fast_osc_en` are 1, and `sys_reset_req` is 0.
- R2: In the run state, a `pmode_wr` cycle loads `pmode_wdata` into `pmode_q`. Bit 0 requests the idle state and bit 1 requests the stop state.
- R3: The halt waits for `insn_done`. `cpu_clk_en` stays 1 until the rising clock edge at which `insn_done` is sampled high, either with the write or after it, and drops in the cycle after that edge.
- R4: In the idle state, `cpu_clk_en` is 0 and `fast_osc_en` stays 1.
- R5: In the stop state, both `cpu_clk_en` and `fast_osc_en` are 0.
- R6: If the written value has both bits set, the controller enters the stop state and `pmode_q` reads 3.
- R7: If `irq_pending` is sampled high in the idle state, bit 0 of `pmode_q` clears and `cpu_clk_en` returns to 1 in the next cycle.
- R8: `irq_pending` has no effect in the stop state.
- R9: Writes to the mode register are ignored while a halt is armed or active. The state and `pmode_q` do not change.
- R10: Asserting `rst_n` low ends idle or stop at once (asynchronously). `pmode_q` returns to 0 and both enables return to 1.
- R11: A rising edge on `wdt_rst_req` produces exactly one `sys_reset_req` pulse.
- R12: When `clkmon_en` is 1 and the fast clock stops, one `sys_reset_req` pulse is issued about `MCD_TICKS` slow ticks later. No pulse is issued while the fast clock runs.
- R13: When `clkmon_en` is 0, a stopped fast clock causes no `sys_reset_req` pulse.
- R14: `sys_reset_req` is never high for two slow ticks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, which is also the monitored clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| slow_clk | input | 1 | Always-on slow clock |
| por_n | input | 1 | Asynchronous active-low reset for the slow domain |
| pmode_wr | input | 1 | Write strobe for the mode register |
| pmode_wdata | input | 2 | Write data: bit 0 idle, bit 1 stop |
| insn_done | input | 1 | The current instruction retires this cycle |
| irq_pending | input | 1 | An enabled interrupt is asserted |
| wdt_rst_req | input | 1 | Watchdog reset request, a level |
| clkmon_en | input | 1 | Enables the missing-clock monitor |
| pmode_q | output | 2 | Mode register contents |
| cpu_clk_en | output | 1 | CPU clock enable |
| fast_osc_en | output | 1 | Fast internal oscillator enable |
| sys_reset_req | output | 1 | Single-tick reset request in the slow-clock domain |

## Verification
The bench sweeps every written mode value against 0, 1 and 2 cycles of retire delay.

- **Early halt:** a design that halted on the write itself would drop `cpu_clk_en` one cycle early.
- **Priority:** a design without stop priority would leave the oscillator running for value 3.
- **Writes while halted:** a write during idle that tries to select stop must change nothing.
- **Interrupt in stop:** an interrupt during stop must not wake a controller that mishandles wake-up.
- **Clock monitor:** with the fast clock actually halted, a monitor with the wrong count or no saturation fires early, fires late or fires repeatedly. A monitor fooled by aliasing would fire while the clock still runs.
- **Watchdog level:** a request held high for several ticks must still give exactly one pulse.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
   typedef enum logic [2:0] {
      PM_RUN      = 3'd0,
      PM_ARM_IDLE = 3'd1,
      PM_ARM_STOP = 3'd2,
      PM_IDLE     = 3'd3,
      PM_STOP     = 3'd4
   } pm_state_e;

   localparam int unsigned PM_IDLE_BIT = 0;
   localparam int unsigned PM_STOP_BIT = 1;
   localparam int unsigned PM_W        = 2;
endpackage

// File: rtl/pwr_mode_sync.sv
module pwr_mode_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   initial begin
      assert (STAGES >= 2) else $error("pwr_mode_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
   import pwr_mode_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pmode_wr,
   input  logic [PM_W-1:0] pmode_wdata,
   input  logic            insn_done,
   input  logic            irq_pending,
   output logic [PM_W-1:0] pmode_q,
   output logic            cpu_clk_en,
   output logic            fast_osc_en
);
   pm_state_e       cur, nxt;
   logic [PM_W-1:0] mode_r;
   logic            wr_ok;
   logic            wake;

   assign wr_ok = pmode_wr && (cur == PM_RUN);
   assign wake  = (cur == PM_IDLE) && irq_pending;

   always_comb begin
      nxt = cur;
      unique case (cur)
         PM_RUN: begin
            if (wr_ok && pmode_wdata[PM_STOP_BIT])
               nxt = insn_done ? PM_STOP : PM_ARM_STOP;
            else if (wr_ok && pmode_wdata[PM_IDLE_BIT])
               nxt = insn_done ? PM_IDLE : PM_ARM_IDLE;
         end
         PM_ARM_IDLE: if (insn_done) nxt = PM_IDLE;
         PM_ARM_STOP: if (insn_done) nxt = PM_STOP;
         PM_IDLE:     if (irq_pending) nxt = PM_RUN;
         PM_STOP:     nxt = PM_STOP;
         default:     nxt = PM_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur    <= PM_RUN;
         mode_r <= '0;
      end else begin
         cur <= nxt;
         if (wr_ok)     mode_r <= pmode_wdata;
         else if (wake) mode_r[PM_IDLE_BIT] <= 1'b0;
      end
   end

   assign pmode_q     = mode_r;
   assign cpu_clk_en  = (cur != PM_IDLE) && (cur != PM_STOP);
   assign fast_osc_en = (cur != PM_STOP);

   // R3: the CPU clock only drops right after an instruction retired
   assert_halt_after_retire_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_clk_en) |-> $past(insn_done));
   // R7: interrupt in idle resumes the CPU and clears the idle bit
   assert_idle_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == PM_IDLE && irq_pending) |=> (cpu_clk_en && !pmode_q[PM_IDLE_BIT]));
   // R8: interrupts never wake the stop state
   assert_stop_no_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == PM_STOP && irq_pending) |=> !fast_osc_en);
   // R5: oscillator off implies CPU clock off
   assert_osc_off_cpu_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !fast_osc_en |-> !cpu_clk_en);
   // R9: register frozen while halted or armed
   assert_frozen_when_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cur != PM_RUN && !wake) |=> $stable(pmode_q));
endmodule

// File: rtl/pwr_mode_clkmon.sv
module pwr_mode_clkmon #(
   parameter int unsigned MCD_TICKS   = 1000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          MCD_PRESENT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_clk,
   input  logic por_n,
   input  logic clkmon_en,
   input  logic wdt_rst_req,
   output logic sys_reset_req
);
   localparam int unsigned CNT_W = $clog2(MCD_TICKS + 1);
   localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(MCD_TICKS);
   localparam logic [CNT_W-1:0] LIMIT_1 = CNT_W'(MCD_TICKS - 1);

   initial begin
      assert (MCD_TICKS > 2 * SYNC_STAGES + 4)
         else $error("pwr_mode_clkmon: MCD_TICKS too small for the handshake round trip");
   end

   logic wdt_s, wdt_d, wdt_rise;
   logic mcd_fire;

   pwr_mode_sync #(.STAGES(SYNC_STAGES)) u_wdt_sync (
      .clk(slow_clk), .rst_n(por_n), .d(wdt_rst_req), .q(wdt_s));

   always_ff @(posedge slow_clk or negedge por_n) begin
      if (!por_n) wdt_d <= 1'b0;
      else        wdt_d <= wdt_s;
   end
   assign wdt_rise = wdt_s && !wdt_d;

   generate
      if (MCD_PRESENT) begin : g_mcd
         logic             req_q, ack_fast, ack_s, en_s, seen;
         logic [CNT_W-1:0] cnt;

         // probe toggle goes to the fast domain and is echoed back
         pwr_mode_sync #(.STAGES(SYNC_STAGES)) u_echo (
            .clk(clk), .rst_n(rst_n), .d(req_q), .q(ack_fast));
         pwr_mode_sync #(.STAGES(SYNC_STAGES)) u_ack (
            .clk(slow_clk), .rst_n(por_n), .d(ack_fast), .q(ack_s));
         pwr_mode_sync #(.STAGES(SYNC_STAGES)) u_en (
            .clk(slow_clk), .rst_n(por_n), .d(clkmon_en), .q(en_s));

         assign seen = (ack_s == req_q);

         always_ff @(posedge slow_clk or negedge por_n) begin
            if (!por_n) begin
               req_q <= 1'b0;
               cnt   <= '0;
            end else begin
               if (seen) req_q <= ~req_q;
               if (!en_s || seen)  cnt <= '0;
               else if (cnt != LIMIT) cnt <= cnt + 1'b1;
            end
         end

         assign mcd_fire = en_s && !seen && (cnt == LIMIT_1);

         // R12: counter saturates at the timeout
         assert_cnt_bound_R12: assert property (@(posedge slow_clk) disable iff (!por_n)
            cnt <= LIMIT);
         // R13: a disabled monitor keeps its counter at zero
         assert_disabled_idle_R13: assert property (@(posedge slow_clk) disable iff (!por_n)
            !en_s |=> (cnt == '0));
      end else begin : g_no_mcd
         assign mcd_fire = 1'b0;
      end
   endgenerate

   always_ff @(posedge slow_clk or negedge por_n) begin
      if (!por_n) sys_reset_req <= 1'b0;
      else        sys_reset_req <= (wdt_rise || mcd_fire) && !sys_reset_req;
   end

   // R14: the request is a single slow tick wide
   assert_single_pulse_R14: assert property (@(posedge slow_clk) disable iff (!por_n)
      sys_reset_req |=> !sys_reset_req);
   // R11: a watchdog edge always yields a request
   assert_wdt_pulse_R11: assert property (@(posedge slow_clk) disable iff (!por_n)
      (wdt_rise && !sys_reset_req) |=> sys_reset_req);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pwr_mode_pkg::*;
#(
   parameter int unsigned MCD_TICKS   = 1000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          MCD_PRESENT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            slow_clk,
   input  logic            por_n,
   input  logic            pmode_wr,
   input  logic [PM_W-1:0] pmode_wdata,
   input  logic            insn_done,
   input  logic            irq_pending,
   input  logic            wdt_rst_req,
   input  logic            clkmon_en,
   output logic [PM_W-1:0] pmode_q,
   output logic            cpu_clk_en,
   output logic            fast_osc_en,
   output logic            sys_reset_req
);
   pwr_mode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .pmode_wr    (pmode_wr),
      .pmode_wdata (pmode_wdata),
      .insn_done   (insn_done),
      .irq_pending (irq_pending),
      .pmode_q     (pmode_q),
      .cpu_clk_en  (cpu_clk_en),
      .fast_osc_en (fast_osc_en)
   );

   pwr_mode_clkmon #(
      .MCD_TICKS   (MCD_TICKS),
      .SYNC_STAGES (SYNC_STAGES),
      .MCD_PRESENT (MCD_PRESENT)
   ) u_mon (
      .clk           (clk),
      .rst_n         (rst_n),
      .slow_clk      (slow_clk),
      .por_n         (por_n),
      .clkmon_en     (clkmon_en),
      .wdt_rst_req   (wdt_rst_req),
      .sys_reset_req (sys_reset_req)
   );
endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;
   localparam int unsigned TICKS = 12;

   logic       clk = 1'b0;
   logic       slow_clk = 1'b0;
   logic       rst_n = 1'b0, por_n = 1'b0;
   logic       pmode_wr = 1'b0, insn_done = 1'b0, irq_pending = 1'b0;
   logic       wdt_rst_req = 1'b0, clkmon_en = 1'b0;
   logic [1:0] pmode_wdata = 2'b00;
   logic [1:0] pmode_q;
   logic       cpu_clk_en, fast_osc_en, sys_reset_req;

   int total = 0;
   int bad = 0;
   int hi_cnt = 0;

   pwr_mode_ctrl #(.MCD_TICKS(TICKS), .SYNC_STAGES(2), .MCD_PRESENT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .por_n(por_n),
      .pmode_wr(pmode_wr), .pmode_wdata(pmode_wdata), .insn_done(insn_done),
      .irq_pending(irq_pending), .wdt_rst_req(wdt_rst_req), .clkmon_en(clkmon_en),
      .pmode_q(pmode_q), .cpu_clk_en(cpu_clk_en), .fast_osc_en(fast_osc_en),
      .sys_reset_req(sys_reset_req));

   // fast oscillator model: stops while its enable is low
   always begin
      #5 clk = 1'b0;
      #5 if (fast_osc_en !== 1'b0) clk = 1'b1;
   end
   always #20 slow_clk = ~slow_clk;

   always @(negedge slow_clk) if (sys_reset_req === 1'b1) hi_cnt++;

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      #23;
      chk("R10 pmode_q after reset", pmode_q, 0);
      chk("R10 cpu_clk_en after reset", cpu_clk_en, 1);
      chk("R10 fast_osc_en after reset", fast_osc_en, 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   // write w, then retire the instruction d cycles later (d=0: same cycle)
   task automatic enter(input int w, input int d);
      @(negedge clk);
      pmode_wr = 1'b1; pmode_wdata = 2'(w); insn_done = (d == 0);
      @(negedge clk);
      pmode_wr = 1'b0; insn_done = 1'b0;
      chk("R2 pmode_q after write", pmode_q, w);
      for (int k = 1; k <= d; k++) begin
         chk("R3 cpu_clk_en before retire", cpu_clk_en, 1);
         if (k == d) insn_done = 1'b1;
         @(negedge clk);
         insn_done = 1'b0;
      end
   endtask

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #50 por_n = 1'b1;
      #30 rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 pmode_q", pmode_q, 0);
      chk("R1 cpu_clk_en", cpu_clk_en, 1);
      chk("R1 fast_osc_en", fast_osc_en, 1);
      chk("R1 sys_reset_req", sys_reset_req, 0);

      for (int w = 0; w < 4; w++) begin
         for (int d = 0; d < 3; d++) begin
            int base;
            enter(w, d);
            if (w == 0) begin
               chk("R2 no halt for zero", cpu_clk_en, 1);
            end else if (w == 1) begin
               chk("R4 idle cpu_clk_en", cpu_clk_en, 0);
               chk("R4 idle fast_osc_en", fast_osc_en, 1);
               pmode_wr = 1'b1; pmode_wdata = 2'b10;
               @(negedge clk);
               pmode_wr = 1'b0;
               @(negedge clk);
               chk("R9 write ignored state", cpu_clk_en + 2 * fast_osc_en, 2);
               chk("R9 write ignored reg", pmode_q, 1);
               if (d == 2) begin
                  do_reset();
               end else begin
                  irq_pending = 1'b1;
                  @(negedge clk);
                  irq_pending = 1'b0;
                  chk("R7 wake cpu_clk_en", cpu_clk_en, 1);
                  chk("R7 idle bit cleared", pmode_q, 0);
               end
            end else begin
               base = hi_cnt;
               chk("R5 stop cpu_clk_en", cpu_clk_en, 0);
               chk("R5 stop fast_osc_en", fast_osc_en, 0);
               if (w == 3) chk("R6 both bits read back", pmode_q, 3);
               irq_pending = 1'b1;
               repeat (4) @(negedge slow_clk);
               irq_pending = 1'b0;
               chk("R8 irq ignored in stop", fast_osc_en, 0);
               repeat (3 * TICKS) @(negedge slow_clk);
               chk("R13 no request with monitor off", hi_cnt - base, 0);
               do_reset();
            end
         end
      end

      // clock monitor: running clock must not trip it
      clkmon_en = 1'b1;
      begin
         int base = hi_cnt;
         repeat (10 * TICKS) @(negedge slow_clk);
         chk("R12 no request while clock runs", hi_cnt - base, 0);
      end
      // stop the fast clock and time the request
      begin
         int base, first;
         enter(2, 0);
         base = hi_cnt; first = 0;
         for (int k = 1; k <= 4 * TICKS; k++) begin
            @(negedge slow_clk);
            if (sys_reset_req === 1'b1 && first == 0) first = k;
         end
         chk("R12 one request after clock loss", hi_cnt - base, 1);
         chk("R14 request one tick wide", hi_cnt - base, 1);
         chk("R12 request not too early", int'(first >= TICKS - 6), 1);
         chk("R12 request not too late", int'(first <= TICKS + 5), 1);
         do_reset();
      end

      // watchdog request held as a level during idle
      clkmon_en = 1'b0;
      repeat (4) @(negedge slow_clk);
      begin
         int base;
         enter(1, 1);
         base = hi_cnt;
         wdt_rst_req = 1'b1;
         repeat (5) @(negedge slow_clk);
         wdt_rst_req = 1'b0;
         repeat (5) @(negedge slow_clk);
         chk("R11 single watchdog request", hi_cnt - base, 1);
         chk("R4 still idle before reset", cpu_clk_en, 0);
         do_reset();
         chk("R10 running after watchdog reset", cpu_clk_en, 1);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule